// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers up to twenty-four interrupt sources into three byte-wide status registers and presents one active-high request line to a host. A source that asserts while its status-mask bit is clear leaves its status bit set, and the bit stays set after the source goes away. The host finds the cause by reading the status bytes and acknowledges by writing to any one of them. That single write empties all three bytes.

There are two mask layers for each source. The status mask decides whether an event is recorded at all. The line mask decides whether a recorded bit may raise the request. Software can therefore leave a source out of the request and still poll it, or shut it out completely. Access goes through a plain byte bus with an address, a write strobe, write data and combinational read data. Writes take effect at the clock edge.

Top module: `irq_status_agg`

## Requirements
- R1: Source n is recorded in the status byte at address n/8, at bit n%8. The status bytes sit at addresses 0, 1 and 2, so reading them in turn gives a little-endian 24-bit value with source 0 in bit 0 of address 0.
- R2: The status-mask bytes sit at addresses 8, 9 and 10, with the same bit layout. A source that is high at a clock edge sets its status bit only when its status-mask bit is 0. A bit of 1 keeps the status bit unchanged.
- R3: A status bit that is set stays set while the source deasserts, for as long as no clearing write happens.
- R4: A write to address 0, 1 or 2 clears all 24 status bits at that clock edge, whatever the write data.
- R5: If a source event that may be latched arrives in the same cycle as a clearing write, its status bit is set after the edge.
- R6: The line-mask bytes sit at addresses 4, 5 and 6, with the same bit layout. irq_o is a register that holds the OR over all bits of (status AND NOT line mask) as they stood before the previous clock edge. The line mask has no effect on latching.
- R7: Source bits 12 and 23 are reserved. They always read as 0 and never raise irq_o.
- R8: Reading any line-mask or status-mask byte returns the last value written to it, all 8 bits.
- R9: After reset every mask byte reads 0xFF, every status byte reads 0x00 and irq_o is low.
- R10: Reading a status byte changes nothing. The same value reads back until a source event or a clearing write.
- R11: Any address not listed above (3, 7, 11 to 15) reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 24 | Interrupt source levels, bit n is source n |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe, sampled at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Registered active-high interrupt request |

## Verification
The bench aims at several specific edge cases:
- A clearing write with a source active in the same cycle. A design that gives the clear priority loses that event.
- Clearing writes that carry 0x00, 0xFF and random data, sent to each of the three status addresses. A design that clears only the addressed byte, or clears only the bits set in the data, leaves stale bits behind.
- A source that is latched but line-masked. A design that gates latching with the line mask, or that lets the line mask leak, raises a request when it should not or drops a recorded bit.
- Reserved sources held high, and writes to unmapped address 3. A design that decodes the bank index loosely clears status or corrupts a mask byte on the write to address 3.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int DEF_BANKS  = 3;
  localparam int DEF_BANK_W = 8;
  localparam int ADDR_W     = 4;

  // address bits [3:2] select the register group, [1:0] the bank
  typedef enum logic [1:0] {
    GRP_STS  = 2'd0,
    GRP_LMSK = 2'd1,
    GRP_SMSK = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  function automatic grp_e addr_group(input logic [ADDR_W-1:0] a);
    case (a[3:2])
      2'd0:    addr_group = GRP_STS;
      2'd1:    addr_group = GRP_LMSK;
      2'd2:    addr_group = GRP_SMSK;
      default: addr_group = GRP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = DEF_BANKS
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  output grp_e               grp_o,
  output logic [1:0]         bank_o,
  output logic               bank_ok_o,
  output logic               clr_o,
  output logic [NUM_BANKS-1:0] lmask_we_o,
  output logic [NUM_BANKS-1:0] smask_we_o
);

  assign grp_o     = addr_group(addr_i);
  assign bank_o    = addr_i[1:0];
  assign bank_ok_o = (int'(addr_i[1:0]) < NUM_BANKS) && (grp_o != GRP_NONE);
  assign clr_o     = wr_en_i && bank_ok_o && (grp_o == GRP_STS);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_we
    assign lmask_we_o[g] = wr_en_i && (grp_o == GRP_LMSK) && (int'(bank_o) == g);
    assign smask_we_o[g] = wr_en_i && (grp_o == GRP_SMSK) && (int'(bank_o) == g);
  end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int          NUM_BANKS = 3,
  parameter int          BANK_W    = 8,
  parameter logic [7:0]  RST_VAL   = 8'hFF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS-1:0]        we_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [NUM_BANKS*BANK_W-1:0] mask_o
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [BANK_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= BANK_W'(RST_VAL);
      else if (we_i[g]) q <= wdata_i;
    end
    assign mask_o[g*BANK_W +: BANK_W] = q;
  end

endmodule

// File: rtl/irq_status_core.sv
module irq_status_core #(
  parameter int              SRC_W = 24,
  parameter logic [SRC_W-1:0] RSVD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic [SRC_W-1:0] smask_i,
  input  logic             clr_i,
  output logic [SRC_W-1:0] set_o,
  output logic [SRC_W-1:0] status_o
);

  // events allowed into status: not status-masked, not reserved
  function automatic logic [SRC_W-1:0] admit(input logic [SRC_W-1:0] s,
                                             input logic [SRC_W-1:0] m);
    admit = s & ~m & ~RSVD;
  endfunction

  // clear first, then OR in new events so a coincident event survives
  function automatic logic [SRC_W-1:0] next_sts(input logic [SRC_W-1:0] cur,
                                                input logic [SRC_W-1:0] ev,
                                                input logic             clr);
    next_sts = (clr ? '0 : cur) | ev;
  endfunction

  assign set_o = admit(src_i, smask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= next_sts(status_o, set_o, clr_i);
  end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] status_i,
  input  logic [NUM_BANKS*BANK_W-1:0] lmask_i,
  output logic                        pend_o,
  output logic                        irq_o
);

  logic [NUM_BANKS-1:0] bank_pend;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_pend
    assign bank_pend[g] = |(status_i[g*BANK_W +: BANK_W] & ~lmask_i[g*BANK_W +: BANK_W]);
  end

  assign pend_o = |bank_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend_o;
  end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = DEF_BANKS,
  parameter int BANK_W    = DEF_BANK_W,
  parameter logic [NUM_BANKS*BANK_W-1:0] RSVD_BITS = 24'h80_1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_en_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [BANK_W-1:0]           rdata_o,
  output logic                        irq_o
);

  localparam int SRC_W = NUM_BANKS * BANK_W;

  grp_e                 grp_w;
  logic [1:0]           bank_w;
  logic                 bank_ok_w;
  logic                 clr_w;
  logic [NUM_BANKS-1:0] lmask_we_w;
  logic [NUM_BANKS-1:0] smask_we_w;
  logic [SRC_W-1:0]     lmask_q;
  logic [SRC_W-1:0]     smask_q;
  logic [SRC_W-1:0]     status_q;
  logic [SRC_W-1:0]     set_w;
  logic                 pend_w;

  irq_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .grp_o      (grp_w),
    .bank_o     (bank_w),
    .bank_ok_o  (bank_ok_w),
    .clr_o      (clr_w),
    .lmask_we_o (lmask_we_w),
    .smask_we_o (smask_we_w)
  );

  irq_mask_bank #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .RST_VAL(8'hFF)) u_lmask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (lmask_we_w),
    .wdata_i (wdata_i),
    .mask_o  (lmask_q)
  );

  irq_mask_bank #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .RST_VAL(8'hFF)) u_smask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (smask_we_w),
    .wdata_i (wdata_i),
    .mask_o  (smask_q)
  );

  irq_status_core #(.SRC_W(SRC_W), .RSVD(RSVD_BITS)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .smask_i  (smask_q),
    .clr_i    (clr_w),
    .set_o    (set_w),
    .status_o (status_q)
  );

  irq_req_gen #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_q),
    .lmask_i  (lmask_q),
    .pend_o   (pend_w),
    .irq_o    (irq_o)
  );

  function automatic logic [BANK_W-1:0] pick(input logic [SRC_W-1:0] v, input logic [1:0] b);
    pick = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (int'(b) == i) pick = v[i*BANK_W +: BANK_W];
  endfunction

  always_comb begin
    rdata_o = '0;
    if (bank_ok_w) begin
      case (grp_w)
        GRP_STS:  rdata_o = pick(status_q, bank_w);
        GRP_LMSK: rdata_o = pick(lmask_q, bank_w);
        GRP_SMSK: rdata_o = pick(smask_q, bank_w);
        default:  rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
  parameter int              SRC_W = 24,
  parameter logic [SRC_W-1:0] RSVD = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_W-1:0] src_i,
  input logic             clr_w,
  input logic [SRC_W-1:0] status_q,
  input logic [SRC_W-1:0] lmask_q,
  input logic [SRC_W-1:0] smask_q,
  input logic             irq_o
);

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & RSVD) == '0);

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && ((src_i & ~smask_q) == '0)) |=> (status_q == '0));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> ((status_q & $past(src_i & ~smask_q & ~RSVD)) == $past(src_i & ~smask_q & ~RSVD)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_w |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_smask_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(smask_q)) == '0));

  assert_irq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~lmask_q) == '0) |=> !irq_o);

  assert_irq_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~lmask_q) != '0) |=> irq_o);

endmodule

bind irq_status_agg irq_status_agg_chk #(.SRC_W(SRC_W), .RSVD(RSVD_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_i    (src_i),
  .clr_w    (clr_w),
  .status_q (status_q),
  .lmask_q  (lmask_q),
  .smask_q  (smask_q),
  .irq_o    (irq_o)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;

  localparam logic [23:0] RSVD = 24'h80_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [23:0] m_st, m_lm, m_sm;

  always #5 clk = ~clk;

  irq_status_agg u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src),
    .addr_i  (addr),
    .wr_en_i (we),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  function automatic logic [7:0] rd_model(input logic [3:0] a);
    if (a[1:0] == 2'd3) return 8'h00;
    case (a[3:2])
      2'd0:    return m_st[a[1:0]*8 +: 8];
      2'd1:    return m_lm[a[1:0]*8 +: 8];
      2'd2:    return m_sm[a[1:0]*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] s, input logic [3:0] a, input logic w,
                      input logic [7:0] d, input bit do_rd, input string tag);
    logic exp_irq;
    @(negedge clk);
    src = s; addr = a; we = w; wdata = d;
    #1;
    if (do_rd) chk(tag, 32'(rdata), 32'(rd_model(a)));
    @(posedge clk);
    exp_irq = |(m_st & ~m_lm);
    m_st = ((w && a[3:2] == 2'd0 && a[1:0] != 2'd3) ? 24'h0 : m_st) | (s & ~m_sm & ~RSVD);
    if (w && a[1:0] != 2'd3 && a[3:2] == 2'd1) m_lm[a[1:0]*8 +: 8] = d;
    if (w && a[1:0] != 2'd3 && a[3:2] == 2'd2) m_sm[a[1:0]*8 +: 8] = d;
    #1;
    chk("R6 irq", 32'(irq), 32'(exp_irq));
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(24'h0, a, 1'b1, d, 1'b0, "wr");
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(24'h0, a, 1'b0, 8'h00, 1'b1, tag);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 16; i++) rd(4'(i), tag);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    m_st = '0; m_lm = '1; m_sm = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 irq after reset", 32'(irq), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    read_all("R9 reset values / R11 unmapped");

    // R2: all status-masked, nothing latches
    step(24'hFF_FFFF, 4'd0, 1'b0, 8'h0, 1'b0, "R2");
    read_all("R2 masked source not latched");

    // open status masks, keep line masks shut
    wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00);
    step(24'h00_0020, 4'd0, 1'b0, 8'h0, 1'b0, "R1");
    rd(4'd0, "R1 bit5 in byte 0");
    step(24'h02_0000, 4'd0, 1'b0, 8'h0, 1'b0, "R1");
    rd(4'd2, "R1 bit17 in byte 2");
    rd(4'd2, "R10 read has no side effect");
    step(24'h0, 4'd0, 1'b0, 8'h0, 1'b0, "R3");
    read_all("R3 sticky after source drops");

    // R6: line mask opens the request
    wr(4'd4, 8'h00);
    rd(4'd0, "R6 line mask does not touch status");
    rd(4'd0, "R6 irq raised");

    // R7: reserved sources
    step(24'hFF_FFFF, 4'd0, 1'b0, 8'h0, 1'b0, "R7");
    rd(4'd1, "R7 bit12 reads zero");
    rd(4'd2, "R7 bit23 reads zero");

    // R11: write to unmapped status bank 3 does not clear
    wr(4'd3, 8'h00);
    wr(4'd7, 8'h12);
    wr(4'd15, 8'h34);
    read_all("R11 unmapped write ignored");

    // R4: clear through each status address with assorted data
    wr(4'd2, 8'h5A);
    read_all("R4 clear via byte 2");
    step(24'h7F_EFFF, 4'd0, 1'b0, 8'h0, 1'b0, "R4");
    wr(4'd1, 8'hFF);
    read_all("R4 clear via byte 1");
    step(24'h00_00F0, 4'd0, 1'b0, 8'h0, 1'b0, "R4");
    wr(4'd0, 8'h00);
    read_all("R4 clear via byte 0");

    // R5: event coincident with clear survives
    step(24'h00_0003, 4'd0, 1'b0, 8'h0, 1'b0, "R5");
    step(24'h02_0000, 4'd1, 1'b1, 8'h77, 1'b0, "R5");
    read_all("R5 event beats clear");

    // R7: only reserved sources, all line masks open
    wr(4'd0, 8'h00); wr(4'd5, 8'h00); wr(4'd6, 8'h00);
    step(RSVD, 4'd0, 1'b0, 8'h0, 1'b0, "R7");
    rd(4'd0, "R7 reserved never raises irq");
    rd(4'd0, "R7 reserved never raises irq");

    // R8: readback
    wr(4'd5, 8'hA5); wr(4'd9, 8'h3C); wr(4'd10, 8'hC3);
    read_all("R8 mask readback");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [23:0] s;
      logic [3:0]  a;
      logic        w;
      s = ($urandom % 4 == 0) ? 24'($urandom) & 24'($urandom) : 24'h0;
      a = 4'($urandom);
      w = ($urandom % 3 == 0);
      step(s, a, w, 8'($urandom), 1'b1, "R1 R2 R4 R8 random");
    end

    finish_run();
  end

endmodule